// File: doc/BRIEF.md
# Serial Character Receiver with Error Routing

The block recovers asynchronous serial characters from a single receive line. Timing comes from the base clock and a run-time bit divisor that gives the number of base clocks per bit. The line passes through a two-flop synchroniser and a three-sample majority vote. A falling level arms a start check. The start bit is confirmed half a bit later, and every following bit is taken at its centre, least significant bit first. The character length can be 7 or 8 data bits. The parity bit can be absent, present but unchecked, odd or even. One stop bit is always checked.

A finished character is presented on a valid/ready output stream, together with its parity, framing and overrun flags. The holding register has one entry. It keeps `rx_valid`, `rx_data` and the flags unchanged until a cycle with `rx_valid` and `rx_ready` both high, and `rx_valid` falls in the next cycle. Back-pressure does not stall reception. If a new character completes while the previous one is still unread, the new character replaces it and is marked as overrun. Each character also produces a one-cycle interrupt pulse. A routing input decides whether a character with an error raises the error pulse or the ordinary completion pulse.

Reception runs only while both `power_en` and `rx_en` are high. Dropping either one abandons any character in progress.

Top module: `serial_rx_core`

## Requirements
- R1: With `len8`=1, a frame of one low start bit, eight data bits sent LSB first, and one high stop bit delivers the eight bits on `rx_data`. A low pulse shorter than half a bit is not confirmed as a start bit and delivers nothing.
- R2: With `len8`=0, seven data bits are received and `rx_data[7]` reads 0.
- R3: `parity_mode` 00 expects no parity bit. 10 expects a parity bit that makes the count of ones odd, and 11 one that makes it even. A mismatch in mode 10 or 11 sets `err_parity`.
- R4: `parity_mode` 01 expects a parity bit but never checks it, whatever its value. `err_parity` stays 0 and parity never causes `irq_err`.
- R5: Only one stop bit is checked. A low stop sample sets `err_frame`, and a new start bit may follow straight after a single stop bit.
- R6: A character that completes while `rx_valid`=1 and `rx_ready`=0 replaces the held data and sets `err_overrun`. A character that completes with nothing unread has `err_overrun`=0.
- R7: An error-free character pulses only `irq_done`. A character with any error pulses only `irq_err` when `err_route`=0, and only `irq_done` when `err_route`=1.
- R8: `rx_valid` stays high with data held until the cycle after `rx_valid`&&`rx_ready`, and then falls.
- R9: Once both enables become high while the line is already low, that low level is taken as a start bit and the character is received.
- R10: With `power_en`=0 or `rx_en`=0 nothing is received. Clearing `rx_en` abandons the frame in progress. After it is set again, the receiver stays reset for 2 base clocks.
- R11: During reset `rx_valid`, `irq_done`, `irq_err` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| power_en | input | 1 | Power enable of the receiver |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial receive line, idle high |
| baud_div | input | DIV_W | Base clocks per bit, at least 4 |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| parity_mode | input | 2 | 00 none, 01 present unchecked, 10 odd, 11 even |
| err_route | input | 1 | 0: errors to irq_err, 1: errors to irq_done |
| rx_valid | output | 1 | Character held on the output stream |
| rx_ready | input | 1 | Consumer accepts the held character |
| rx_data | output | DATA_W | Received character |
| err_parity | output | 1 | Parity error of the held character |
| err_frame | output | 1 | Framing error of the held character |
| err_overrun | output | 1 | Held character overwrote an unread one |
| irq_done | output | 1 | One-cycle completion pulse |
| irq_err | output | 1 | One-cycle error pulse |

## Verification
A table of frames covers both character lengths, every parity mode (each with a correct bit and a flipped bit), good and bad stop bits, and both routing settings. Together these separate the parity judgement, the framing check and the interrupt choice from one another. Directed frames then probe the edges of the function:
- a short low glitch, to show that start confirmation waits until mid-bit;
- two characters separated by a single stop bit, to show that only one stop bit is required;
- two characters with no read between them, to show the overrun case;
- frames sent while disabled, and a frame abandoned by a short drop of `rx_en`, for the enable behaviour;
- enabling while the line is already low, to show that a low level counts as a start.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic overrun;
    logic framing;
    logic parity;
  } rx_flags_t;
endpackage

// File: rtl/srx_enable_gate.sv
module srx_enable_gate #(
  parameter int HOLD_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic power_en,
  input  logic rx_en,
  output logic run_o
);
  localparam int HW = $clog2(HOLD_CLKS + 1);

  logic [HW-1:0] hold_q;
  logic          active;

  assign active = power_en & rx_en;

  // While disabled the hold count is reloaded; once enabled it must drain
  // to zero before the frame engine leaves reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= HW'(HOLD_CLKS);
    end else if (!active) begin
      hold_q <= HW'(HOLD_CLKS);
    end else if (hold_q != '0) begin
      hold_q <= hold_q - HW'(1);
    end
  end

  assign run_o = active && (hold_q == '0);
endmodule

// File: rtl/srx_line_sampler.sv
module srx_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [2:0]             hist_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b1;
        else        sync_q[0] <= rxd;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b1;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 3'b111;
    else        hist_q <= {hist_q[1:0], sync_q[SYNC_STAGES-1]};
  end

  // two of the last three samples decide the level
  assign line_o = (hist_q[0] & hist_q[1]) | (hist_q[0] & hist_q[2]) |
                  (hist_q[1] & hist_q[2]);
endmodule

// File: rtl/srx_frame_engine.sv
module srx_frame_engine
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              line,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              len8,
  input  logic [1:0]        parity_mode,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam int BN_W = $clog2(DATA_W);

  par_mode_e         mode;
  rx_state_e         state_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [BN_W-1:0]   bit_q;
  logic [DATA_W-1:0] shift_q;
  logic              acc_q;
  logic              perr_q;
  logic [DIV_W-1:0]  half_pt;
  logic [DIV_W-1:0]  full_pt;
  logic              hit_half;
  logic              hit_full;
  logic [BN_W-1:0]   last_bit;

  assign mode     = par_mode_e'(parity_mode);
  assign half_pt  = baud_div >> 1;
  assign full_pt  = baud_div - DIV_W'(1);
  assign hit_half = (cnt_q == half_pt);
  assign hit_full = (cnt_q == full_pt);
  assign last_bit = len8 ? BN_W'(DATA_W - 1) : BN_W'(DATA_W - 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      acc_q   <= 1'b0;
      perr_q  <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else if (!run) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      cnt_q  <= cnt_q + DIV_W'(1);
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (!line) state_q <= ST_START;
        end
        ST_START: begin
          if (hit_half) begin
            cnt_q <= '0;
            if (!line) begin
              state_q <= ST_DATA;
              bit_q   <= '0;
              acc_q   <= 1'b0;
              perr_q  <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_DATA: begin
          if (hit_full) begin
            cnt_q   <= '0;
            shift_q <= {line, shift_q[DATA_W-1:1]};
            acc_q   <= acc_q ^ line;
            bit_q   <= bit_q + BN_W'(1);
            if (bit_q == last_bit)
              state_q <= (mode == PAR_NONE) ? ST_STOP : ST_PAR;
          end
        end
        ST_PAR: begin
          if (hit_full) begin
            cnt_q <= '0;
            case (mode)
              PAR_ODD:  perr_q <= ~(acc_q ^ line);
              PAR_EVEN: perr_q <= acc_q ^ line;
              default:  perr_q <= 1'b0;
            endcase
            state_q <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (hit_full) begin
            cnt_q   <= '0;
            done_o  <= 1'b1;
            ferr_o  <= ~line;
            perr_o  <= perr_q;
            data_o  <= len8 ? shift_q : {1'b0, shift_q[DATA_W-1:1]};
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_out_stage.sv
module srx_out_stage
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] data_in,
  input  logic              perr,
  input  logic              ferr,
  input  logic              err_route,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output rx_flags_t         flags,
  output logic              irq_done,
  output logic              irq_err
);
  logic ovr_now;
  logic any_err;

  assign ovr_now = rx_valid && !rx_ready;
  assign any_err = perr | ferr | ovr_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      flags    <= '0;
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
      if (done) begin
        rx_valid      <= 1'b1;
        rx_data       <= data_in;
        flags.parity  <= perr;
        flags.framing <= ferr;
        flags.overrun <= ovr_now;
        irq_done      <= !any_err || err_route;
        irq_err       <= any_err && !err_route;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CLKS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_en,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              len8,
  input  logic [1:0]        parity_mode,
  input  logic              err_route,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              irq_done,
  output logic              irq_err
);
  logic              run;
  logic              line;
  logic              done;
  logic [DATA_W-1:0] char_data;
  logic              char_perr;
  logic              char_ferr;
  rx_flags_t         flags;

  srx_enable_gate #(.HOLD_CLKS(HOLD_CLKS)) u_gate (
    .clk(clk), .rst_n(rst_n), .power_en(power_en), .rx_en(rx_en), .run_o(run)
  );

  srx_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .line_o(line)
  );

  srx_frame_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .run(run), .line(line), .baud_div(baud_div),
    .len8(len8), .parity_mode(parity_mode), .done_o(done), .data_o(char_data),
    .perr_o(char_perr), .ferr_o(char_ferr)
  );

  srx_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .done(done), .data_in(char_data),
    .perr(char_perr), .ferr(char_ferr), .err_route(err_route),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .flags(flags), .irq_done(irq_done), .irq_err(irq_err)
  );

  assign err_parity  = flags.parity;
  assign err_frame   = flags.framing;
  assign err_overrun = flags.overrun;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              power_en,
  input logic              rx_en,
  input logic [1:0]        parity_mode,
  input logic              err_route,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              err_parity,
  input logic              err_frame,
  input logic              err_overrun,
  input logic              irq_done,
  input logic              irq_err
);
  assert_irq_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_done && irq_err));

  assert_err_routed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (!$past(err_route) && (err_parity || err_frame || err_overrun)));

  assert_irq_with_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done || irq_err) |-> rx_valid);

  assert_hold_until_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && (irq_done || irq_err || $stable(rx_data))));

  assert_no_parity_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_done || irq_err) && !parity_mode[1]) |-> !err_parity);

  assert_overrun_new_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> (irq_done || irq_err));

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(power_en && rx_en) |=> !(irq_done || irq_err));
endmodule

bind serial_rx_core srx_checker #(.DATA_W(DATA_W)) u_srx_checker (
  .clk(clk), .rst_n(rst_n), .power_en(power_en), .rx_en(rx_en),
  .parity_mode(parity_mode), .err_route(err_route), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .err_parity(err_parity),
  .err_frame(err_frame), .err_overrun(err_overrun), .irq_done(irq_done),
  .irq_err(irq_err)
);

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BIT        = 16;
  localparam int WD_CYCLES  = 100000;
  localparam int NV         = 10;

  // [15] len8 [14:13] parity_mode [12] route [11:4] data [3] flip parity
  // [2] stop bit value [1] expected parity error [0] expected framing error
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 2'b00, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b0, 2'b00, 1'b0, 8'hD3, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b1, 2'b10, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b1, 2'b10, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b1, 2'b11, 1'b1, 8'h81, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b0, 2'b11, 1'b0, 8'h7E, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b1, 2'b01, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b1, 2'b00, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b1},
    {1'b1, 2'b00, 1'b1, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b1},
    {1'b0, 2'b10, 1'b0, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        power_en = 1'b1;
  logic        rx_en = 1'b1;
  logic        rxd = 1'b1;
  logic [11:0] baud_div = 12'(BIT);
  logic        len8 = 1'b1;
  logic [1:0]  parity_mode = 2'b00;
  logic        err_route = 1'b0;
  logic        rx_ready = 1'b0;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        err_parity, err_frame, err_overrun, irq_done, irq_err;

  int n_chk = 0;
  int n_fail = 0;
  int cnt_done = 0;
  int cnt_err = 0;
  int acc_n = 0;
  logic [7:0] acc_last = 8'h00;
  logic wd_hit = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_rx_core u_serial_rx_core (
    .clk(clk), .rst_n(rst_n), .power_en(power_en), .rx_en(rx_en), .rxd(rxd),
    .baud_div(baud_div), .len8(len8), .parity_mode(parity_mode),
    .err_route(err_route), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .irq_done(irq_done), .irq_err(irq_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_done) cnt_done <= cnt_done + 1;
      if (irq_err)  cnt_err  <= cnt_err + 1;
      if (rx_valid && rx_ready) begin
        acc_n    <= acc_n + 1;
        acc_last <= rx_data;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic l8, input logic [1:0] pm,
                            input logic flip, input logic stop);
    logic [7:0] dm;
    logic       pb;
    dm = l8 ? d : (d & 8'h7F);
    drive_bit(1'b0);
    for (int b = 0; b < (l8 ? 8 : 7); b++) drive_bit(dm[b]);
    if (pm != 2'b00) begin
      case (pm)
        2'b01:   pb = 1'b0;
        2'b10:   pb = ~(^dm);
        default: pb = ^dm;
      endcase
      drive_bit(pb ^ flip);
    end
    drive_bit(stop);
    rxd = 1'b1;
  endtask

  task automatic wait_valid(input int limit);
    for (int k = 0; k < limit && !rx_valid; k++) @(negedge clk);
  endtask

  task automatic take;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic run_tests;
    int d0, e0, a0;
    logic [15:0] v;
    logic exp_err;
    string tag_d, tag_p;

    repeat (5) @(negedge clk);
    // R11: reset state
    check("R11 valid", rx_valid, 0);
    check("R11 irq", {irq_done, irq_err}, 0);
    check("R11 flags", {err_parity, err_frame, err_overrun}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      len8 = v[15];
      parity_mode = v[14:13];
      err_route = v[12];
      tag_d = v[15] ? "R1 data" : "R2 data";
      tag_p = (v[14:13] == 2'b01) ? "R4 parity" : "R3 parity";
      exp_err = (v[1] | v[0]) & ~v[12];
      repeat (2) @(negedge clk);
      d0 = cnt_done;
      e0 = cnt_err;
      send_frame(v[11:4], v[15], v[14:13], v[3], v[2]);
      wait_valid(4 * BIT);
      check("R1 valid", rx_valid, 1);
      check(tag_d, rx_data, v[15] ? v[11:4] : {1'b0, v[10:4]});
      check(tag_p, err_parity, v[1]);
      check("R5 frame", err_frame, v[0]);
      check("R6 overrun", err_overrun, 0);
      check("R7 irq_done", cnt_done - d0, {31'd0, ~exp_err});
      check("R7 irq_err", cnt_err - e0, {31'd0, exp_err});
      repeat (3) @(negedge clk);
      check("R8 held", {rx_valid, rx_data}, {1'b1, v[15] ? v[11:4] : {1'b0, v[10:4]}});
      take();
      check("R8 cleared", rx_valid, 0);
    end

    // R6: second character with no read in between
    len8 = 1'b1; parity_mode = 2'b00; err_route = 1'b0;
    d0 = cnt_done; e0 = cnt_err;
    send_frame(8'h11, 1'b1, 2'b00, 1'b0, 1'b1);
    send_frame(8'h22, 1'b1, 2'b00, 1'b0, 1'b1);
    check("R6 data replaced", rx_data, 8'h22);
    check("R6 overrun set", err_overrun, 1);
    check("R7 overrun to irq_err", cnt_err - e0, 1);
    check("R7 first to irq_done", cnt_done - d0, 1);
    take();
    send_frame(8'h33, 1'b1, 2'b00, 1'b0, 1'b1);
    wait_valid(4 * BIT);
    check("R6 overrun clear", {err_overrun, rx_data}, {1'b0, 8'h33});
    take();

    // R1: glitch shorter than half a bit
    d0 = cnt_done; e0 = cnt_err;
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    check("R1 glitch ignored", {rx_valid, 8'(cnt_done - d0), 8'(cnt_err - e0)}, 0);

    // R5: next start right after one stop bit
    rx_ready = 1'b1;
    a0 = acc_n; e0 = cnt_err;
    send_frame(8'h96, 1'b1, 2'b00, 1'b0, 1'b1);
    send_frame(8'h69, 1'b1, 2'b00, 1'b0, 1'b1);
    repeat (2 * BIT) @(negedge clk);
    check("R5 back to back count", acc_n - a0, 2);
    check("R5 back to back data", acc_last, 8'h69);
    check("R5 back to back no error", cnt_err - e0, 0);
    rx_ready = 1'b0;

    // R10: disabled by rx_en, then by power_en
    rx_en = 1'b0;
    send_frame(8'h44, 1'b1, 2'b00, 1'b0, 1'b1);
    repeat (BIT) @(negedge clk);
    check("R10 rx_en off", rx_valid, 0);
    rx_en = 1'b1;
    power_en = 1'b0;
    send_frame(8'h45, 1'b1, 2'b00, 1'b0, 1'b1);
    repeat (BIT) @(negedge clk);
    check("R10 power off", rx_valid, 0);
    power_en = 1'b1;
    repeat (4) @(negedge clk);

    // R10: frame abandoned by a one-clock drop of rx_en
    drive_bit(1'b0);
    drive_bit(1'b1);
    drive_bit(1'b0);
    rxd = 1'b1;
    repeat (BIT / 2) @(negedge clk);
    rx_en = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    check("R10 abandoned frame", rx_valid, 0);
    send_frame(8'h5C, 1'b1, 2'b00, 1'b0, 1'b1);
    wait_valid(4 * BIT);
    check("R10 recovers", {rx_valid, rx_data}, {1'b1, 8'h5C});
    take();

    // R9: enable while the line is already low
    rx_en = 1'b0;
    rxd = 1'b0;
    repeat (10) @(negedge clk);
    rx_en = 1'b1;
    send_frame(8'hC3, 1'b1, 2'b00, 1'b0, 1'b1);
    wait_valid(4 * BIT);
    check("R9 low start", {rx_valid, rx_data, err_frame}, {1'b1, 8'hC3, 1'b0});
    take();
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (WD_CYCLES) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule